// File: doc/BRIEF.md
# Kernel Stream Queue Dispatcher

This block takes kernel launch commands from a host interface. Each command carries a kernel identifier and a stream identifier. The stream identifier selects one of a fixed set of hardware queues. Each queue is a first-in first-out buffer. A queue runs at most one kernel at a time. Its next kernel is released only after the running kernel reports completion by its identifier. Streams that land in the same queue are therefore run one after another, in arrival order. Kernels held in different queues may run side by side.

A global limit caps the number of kernels running at once. When several queue heads could start in the same cycle, a rotating arbiter releases one of them per cycle. Each release is a single-cycle start pulse toward the downstream block distributor. The pulse carries the kernel identifier and the index of the queue it came from.

Top module: `kq_dispatch`

## Requirements
- R1: While reset is asserted and right after it, no start pulse is issued, every queue is empty, no kernel counts as running, and cmd_ready is 1.
- R2: The queue for a command is its stream identifier modulo NUM_QUEUES, taken as the low log2(NUM_QUEUES) bits of cmd_sid. start_queue reports that index with each start.
- R3: Each queue holds QDEPTH waiting kernels. cmd_ready is 0 exactly when the queue selected by the present cmd_sid is full. Commands aimed at other queues are still accepted.
- R4: A command is taken on a rising edge where cmd_valid and cmd_ready are both 1. A start is a one-cycle pulse of start_valid that carries start_kid and start_queue.
- R5: Within one stream, kernels start in arrival order. A later kernel does not start until the earlier one has completed.
- R6: Different streams that share a queue are run one after another in the order their commands were accepted.
- R7: Kernels held in different queues may be running at the same time.
- R8: No more than MAX_ACTIVE kernels run at once. While that many are running, no start is issued.
- R9: At most one start is issued per cycle. Among eligible queue heads, the first one after the most recently started queue, in rising index order with wrap-around, is chosen.
- R10: A completion (done_valid with done_kid) ends the running kernel with that identifier. That frees its queue and lowers the running count in the same edge. A completion whose identifier matches no running kernel has no effect.
- R11: An idle queue, with room under the cap and no competitor, raises start_valid on the second rising edge after the command is accepted. After a completion edge, the next waiting kernel of that queue starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Launch command present |
| cmd_ready | output | 1 | Selected queue can take the command |
| cmd_kid | input | KID_W | Kernel identifier of the command |
| cmd_sid | input | SID_W | Stream identifier of the command |
| start_valid | output | 1 | One-cycle kernel start pulse |
| start_kid | output | KID_W | Identifier of the started kernel |
| start_queue | output | log2(NUM_QUEUES) | Queue the started kernel came from |
| done_valid | input | 1 | Kernel completion report |
| done_kid | input | KID_W | Identifier of the completed kernel |

## Verification
The assertions assume that kernel identifiers are unique among running kernels. They also assume that a completion names at most one running kernel, so the running count stays equal to the number of busy queues. The stimulus gives every launched kernel a fresh identifier. It reports completion only for kernels it has seen start, with one deliberate report of an unknown identifier. It never sends a command while the selected queue shows cmd_ready low.

// File: rtl/kq_pkg.sv
package kq_pkg;
    parameter int unsigned KQ_DEF_QUEUES = 8;
    parameter int unsigned KQ_DEF_DEPTH  = 8;
    parameter int unsigned KQ_DEF_ACTIVE = 32;
    parameter int unsigned KQ_DEF_KID_W  = 8;
    parameter int unsigned KQ_DEF_SID_W  = 6;
endpackage

// File: rtl/kq_fifo.sv
module kq_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R3: the dispatcher never writes into a full queue
    p_push_not_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: a queue is only popped when it holds a kernel
    p_pop_not_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/kq_rr_arb.sv
module kq_rr_arb #(
    parameter int unsigned N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int unsigned IW = $clog2(N);

    logic [IW-1:0] last_d, last_q;

    always_comb begin
        int cand;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 1; k <= int'(N); k++) begin
            cand = (int'(last_q) + k) % int'(N);
            if (!gnt_any && req[cand]) begin
                gnt_any   = 1'b1;
                gnt_idx   = IW'(cand);
                gnt[cand] = 1'b1;
            end
        end
        last_d = gnt_any ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IW'(N - 1);
        else        last_q <= last_d;
    end

    // R9: at most one grant per cycle, always to a requester
    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));
    // R9: a pending request is never left without a grant
    p_grant_when_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> gnt_any);
endmodule

// File: rtl/kq_dispatch.sv
module kq_dispatch
    import kq_pkg::*;
#(
    parameter int unsigned NUM_QUEUES = KQ_DEF_QUEUES,
    parameter int unsigned QDEPTH     = KQ_DEF_DEPTH,
    parameter int unsigned MAX_ACTIVE = KQ_DEF_ACTIVE,
    parameter int unsigned KID_W      = KQ_DEF_KID_W,
    parameter int unsigned SID_W      = KQ_DEF_SID_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [KID_W-1:0]              cmd_kid,
    input  logic [SID_W-1:0]              cmd_sid,
    output logic                          start_valid,
    output logic [KID_W-1:0]              start_kid,
    output logic [$clog2(NUM_QUEUES)-1:0] start_queue,
    input  logic                          done_valid,
    input  logic [KID_W-1:0]              done_kid
);
    localparam int unsigned QSEL_W = $clog2(NUM_QUEUES);
    localparam int unsigned CNT_W  = $clog2(MAX_ACTIVE + 1);

    typedef struct packed {
        logic [NUM_QUEUES-1:0]            running;
        logic [NUM_QUEUES-1:0][KID_W-1:0] run_kid;
        logic [CNT_W-1:0]                 active;
        logic                             start_valid;
        logic [KID_W-1:0]                 start_kid;
        logic [QSEL_W-1:0]                start_queue;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic [QSEL_W-1:0]                cmd_q;
    logic [NUM_QUEUES-1:0]            fifo_push;
    logic [NUM_QUEUES-1:0]            fifo_empty;
    logic [NUM_QUEUES-1:0]            fifo_full;
    logic [NUM_QUEUES-1:0][KID_W-1:0] fifo_head;
    logic [NUM_QUEUES-1:0]            head_req;
    logic [NUM_QUEUES-1:0]            gnt;
    logic [QSEL_W-1:0]                gnt_idx;
    logic                             gnt_any;
    logic                             room;
    logic                             done_hit;

    assign cmd_q     = cmd_sid[QSEL_W-1:0];
    assign cmd_ready = !fifo_full[cmd_q];
    assign room      = (st_q.active < CNT_W'(MAX_ACTIVE));

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        assign fifo_push[q] = cmd_valid && cmd_ready && (cmd_q == QSEL_W'(q));
        assign head_req[q]  = !fifo_empty[q] && !st_q.running[q] && room;

        kq_fifo #(
            .W     (KID_W),
            .DEPTH (QDEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (fifo_push[q]),
            .din   (cmd_kid),
            .pop   (gnt[q]),
            .head  (fifo_head[q]),
            .empty (fifo_empty[q]),
            .full  (fifo_full[q])
        );
    end

    kq_rr_arb #(
        .N (NUM_QUEUES)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (head_req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_comb begin
        st_d             = st_q;
        st_d.start_valid = 1'b0;
        done_hit         = 1'b0;
        for (int q = 0; q < int'(NUM_QUEUES); q++) begin
            if (done_valid && st_q.running[q] && (st_q.run_kid[q] == done_kid)) begin
                st_d.running[q] = 1'b0;
                done_hit        = 1'b1;
            end
        end
        if (gnt_any) begin
            st_d.running[gnt_idx] = 1'b1;
            st_d.run_kid[gnt_idx] = fifo_head[gnt_idx];
            st_d.start_valid      = 1'b1;
            st_d.start_kid        = fifo_head[gnt_idx];
            st_d.start_queue      = gnt_idx;
        end
        st_d.active = st_q.active + CNT_W'(gnt_any) - CNT_W'(done_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_valid = st_q.start_valid;
    assign start_kid   = st_q.start_kid;
    assign start_queue = st_q.start_queue;

    // R8: the running count never exceeds the cap
    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active <= CNT_W'(MAX_ACTIVE));
    // R8: at the cap with no completion, nothing starts next cycle
    p_hold_at_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == CNT_W'(MAX_ACTIVE)) && !done_valid |=> !start_valid);
    // R7: the running count equals the number of busy queues
    p_count_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active == CNT_W'($countones(st_q.running)));
    // R5: a started kernel is recorded as the running kernel of its queue
    p_start_marks_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> st_q.running[start_queue] && (st_q.run_kid[start_queue] == start_kid));
endmodule

// File: tb/kq_dispatch_tb.sv
module kq_dispatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NQ    = 8;
    localparam int QD    = 8;
    localparam int MAXA  = 3;
    localparam int KW    = 8;
    localparam int SW    = 6;
    localparam int NVEC  = 8;

    localparam logic [SW-1:0] VEC_SID [NVEC] = '{6'd0, 6'd9, 6'd18, 6'd27, 6'd36, 6'd45, 6'd54, 6'd63};
    localparam logic [KW-1:0] VEC_KID [NVEC] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8};
    localparam logic [2:0]    VEC_Q   [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [KW-1:0] cmd_kid = '0;
    logic [SW-1:0] cmd_sid = '0;
    logic          start_valid;
    logic [KW-1:0] start_kid;
    logic [2:0]    start_queue;
    logic          done_valid = 1'b0;
    logic [KW-1:0] done_kid = '0;

    int checks = 0;
    int failures = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    kq_dispatch #(
        .NUM_QUEUES (NQ),
        .QDEPTH     (QD),
        .MAX_ACTIVE (MAXA),
        .KID_W      (KW),
        .SID_W      (SW)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_kid     (cmd_kid),
        .cmd_sid     (cmd_sid),
        .start_valid (start_valid),
        .start_kid   (start_kid),
        .start_queue (start_queue),
        .done_valid  (done_valid),
        .done_kid    (done_kid)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_start(input int kid, input int q, input string req);
        chk(start_valid === 1'b1, req, "start_valid", int'(start_valid), 1);
        chk(start_kid === KW'(kid), req, "start_kid", int'(start_kid), kid);
        chk(start_queue === 3'(q), req, "start_queue", int'(start_queue), q);
    endtask

    task automatic expect_idle(input string req);
        chk(start_valid === 1'b0, req, "start_valid idle", int'(start_valid), 0);
    endtask

    // accepted on the next edge; returns just after that edge
    task automatic push(input int sid, input int kid, input string req);
        cmd_sid   = SW'(sid);
        cmd_kid   = KW'(kid);
        cmd_valid = 1'b1;
        #1;
        chk(cmd_ready === 1'b1, req, "cmd_ready before push", int'(cmd_ready), 1);
        step();
        cmd_valid = 1'b0;
    endtask

    // completion sampled on the next edge; returns just after it
    task automatic finish_kernel(input int kid);
        done_kid   = KW'(kid);
        done_valid = 1'b1;
        step();
        done_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        // R1: reset state
        step();
        step();
        expect_idle("R1");
        chk(cmd_ready === 1'b1, "R1", "cmd_ready in reset", int'(cmd_ready), 1);
        rst_n = 1'b1;
        step();
        expect_idle("R1");
        chk(cmd_ready === 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);

        // R2 R4 R11: vector table, one kernel per stream through an idle queue
        for (int i = 0; i < NVEC; i++) begin
            push(int'(VEC_SID[i]), int'(VEC_KID[i]), "R4");
            expect_idle("R11");
            step();
            expect_start(int'(VEC_KID[i]), int'(VEC_Q[i]), "R2");
            step();
            expect_idle("R4");
            finish_kernel(int'(VEC_KID[i]));
            expect_idle("R10");
        end

        // R5: same-stream kernels start in order, each after the previous completes
        push(2, 10, "R5");
        expect_idle("R11");
        push(2, 11, "R5");
        expect_start(10, 2, "R5");
        push(2, 12, "R5");
        expect_idle("R5");
        for (int i = 0; i < 3; i++) begin
            step();
            expect_idle("R5");
        end
        finish_kernel(10);
        expect_idle("R11");
        step();
        expect_start(11, 2, "R11");
        finish_kernel(11);
        expect_idle("R5");
        step();
        expect_start(12, 2, "R5");
        finish_kernel(12);

        // R6: streams 9 and 1 share queue 1 and are serialized
        push(9, 20, "R6");
        push(1, 21, "R6");
        expect_start(20, 1, "R6");
        step();
        expect_idle("R6");
        step();
        expect_idle("R6");
        finish_kernel(20);
        expect_idle("R6");
        step();
        expect_start(21, 1, "R6");
        finish_kernel(21);
        step();

        // R7 R8: concurrency up to the cap of three
        push(0, 30, "R7");
        push(1, 31, "R7");
        expect_start(30, 0, "R7");
        push(2, 32, "R7");
        expect_start(31, 1, "R7");
        push(3, 33, "R8");
        expect_start(32, 2, "R7");
        push(5, 35, "R8");
        expect_idle("R8");
        push(6, 36, "R8");
        expect_idle("R8");
        step();
        expect_idle("R8");
        finish_kernel(31);
        expect_idle("R8");
        step();
        expect_start(33, 3, "R9");
        finish_kernel(30);
        step();
        expect_start(35, 5, "R9");
        push(4, 44, "R8");
        expect_idle("R8");
        // R10: unknown identifier has no effect (a free slot would start q4 or q6)
        finish_kernel(99);
        expect_idle("R10");
        step();
        expect_idle("R10");
        step();
        expect_idle("R10");
        // R9: after q5, q6 is chosen ahead of q4
        finish_kernel(32);
        step();
        expect_start(36, 6, "R9");
        finish_kernel(33);
        step();
        expect_start(44, 4, "R9");
        finish_kernel(35);
        finish_kernel(36);
        finish_kernel(44);
        step();
        expect_idle("R10");

        // R3: fill queue 5 behind a running kernel
        push(5, 50, "R3");
        step();
        expect_start(50, 5, "R3");
        for (int i = 0; i < QD; i++) begin
            push(5 + 8 * (i % 4), 51 + i, "R3");
            expect_idle("R3");
        end
        cmd_sid   = SW'(29);
        cmd_kid   = KW'(77);
        cmd_valid = 1'b1;
        #1;
        chk(cmd_ready === 1'b0, "R3", "cmd_ready full queue", int'(cmd_ready), 0);
        cmd_sid = SW'(3);
        #1;
        chk(cmd_ready === 1'b1, "R3", "cmd_ready other queue", int'(cmd_ready), 1);
        cmd_valid = 1'b0;
        for (int i = 0; i < QD; i++) begin
            finish_kernel(50 + i);
            expect_idle("R3");
            step();
            expect_start(51 + i, 5, "R3");
        end
        finish_kernel(58);
        step();
        expect_idle("R3");

        report();
    end
endmodule